// File: doc/BRIEF.md
# I2C Target with Per-Event Status

This block is an I2C target for 7-bit addressing. It sits on a shared open-drain bus and is run by a host CPU through a small bank of byte-wide registers: a control register, an event status register, an interrupt-enable register, an own-address register and a single data port. The core clock samples SCL and SDA through a short synchroniser. The block finds START and STOP conditions, matches the first byte against its own address, acknowledges it, and reports the transfer direction to software.

In a write transfer each received byte is put on the data port and flagged. In a read transfer the block flags that it needs a byte, takes the next byte from the data port and shifts it out MSB first. While software still owes it service, the block holds SCL low. Every event has its own sticky status bit. Software clears a bit by writing zero to it. A single interrupt line is raised from the status bits that are enabled. A control bit makes the block refuse received data bytes.

Top module: `i2c_tgt_evt`

## Requirements
- R1: After a synchronous reset, all registers read zero, both bus lines are released and the interrupt line is low.
- R2: The first byte after a START is acknowledged only when the interface-enable bit (control bit 2) is set and byte bits 7:1 equal the 7-bit own address (offset 3, stored unshifted). Bit 0 of that byte is the direction, with 1 meaning read. Any other first byte is not acknowledged and the rest of that transfer is ignored.
- R3: A matched address sets status bit 0 (address seen) and loads status bit 5 with the direction bit.
- R4: A first byte of 0x00 is acknowledged, and status bit 6 is set, only when control bit 1 is set.
- R5: In a write transfer each data byte is acknowledged, can be read at the data port (offset 4), and sets status bit 1.
- R6: While status bit 1 is pending in a write, or status bit 3 is pending in a read, the block drives SCL low. It releases SCL once software clears that bit.
- R7: When control bit 0 is set as a data byte completes, the block leaves SDA released in the acknowledge slot (NACK). Control bit 0 stays set until software writes it.
- R8: In a read transfer, status bit 3 is set after the address, and again after each byte the controller acknowledges. The byte last written to the data port is sent MSB first. Status bit 2 is set when a byte has been sent.
- R9: Status bit 4 is set on a STOP (SDA rising while SCL is high), but only if the block was addressed in that transfer.
- R10: A write to the status register (offset 1) clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R11: The interrupt output is high exactly when some status bit and the same bit of the interrupt-enable register (offset 2) are both set.
- R12: The control register (offset 0, four bits; bit 3 is a stored buffer-mode bit) and the own-address register read back what was written, with the unused upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, also used to sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for the register at reg_addr |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| scl_oe | output | 1 | When high, SCL is pulled low |
| sda_oe | output | 1 | When high, SDA is pulled low |
| irq | output | 1 | Combined interrupt request |

## Verification
If the phase or bit counter is wrong, it shows up within one byte. The acknowledge slot carries the wrong level, or a returned byte is shifted by one position. The exhaustive address sweep exposes a bad match or a bad general-call decision in the acknowledge bit of that same transfer. A hold release bound to the wrong status bit shows as SCL low at the next bit with no service pending, or as SCL already high while the bench still finds the bit set. A bad status clear mask shows at the next register read.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int ADR_W = 7;
    localparam int NST   = 7;
    localparam int NCTL  = 4;

    localparam logic [AW-1:0] OFS_CTRL = 3'd0;
    localparam logic [AW-1:0] OFS_STAT = 3'd1;
    localparam logic [AW-1:0] OFS_IEN  = 3'd2;
    localparam logic [AW-1:0] OFS_OWN  = 3'd3;
    localparam logic [AW-1:0] OFS_DATA = 3'd4;

    localparam int C_NACK = 0;
    localparam int C_GCEN = 1;
    localparam int C_EN   = 2;
    localparam int C_BUF  = 3;

    localparam int S_ADR  = 0;
    localparam int S_DRX  = 1;
    localparam int S_DTX  = 2;
    localparam int S_DEMP = 3;
    localparam int S_STOP = 4;
    localparam int S_DIR  = 5;
    localparam int S_GC   = 6;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_AACK, PH_RX, PH_RACK, PH_TX, PH_TACK, PH_SKIP
    } phase_e;

    typedef struct packed {
        logic gc;
        logic dir;
        logic stop;
        logic demp;
        logic dtx;
        logic drx;
        logic adr;
    } evt_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } line_t;

    function automatic logic addr_hit(input logic [DW-1:0] first,
                                      input logic [ADR_W-1:0] own,
                                      input logic gc_en);
        return (first[DW-1:1] == own) || (gc_en && first == '0);
    endfunction

    function automatic logic [NST-1:0] stat_next(input logic [NST-1:0] cur,
                                                 input logic [NST-1:0] clr,
                                                 input evt_t e);
        logic [NST-1:0] n;
        n = cur & ~clr;
        if (e.adr) begin
            n[S_ADR] = 1'b1;
            n[S_DIR] = e.dir;
        end
        if (e.gc)   n[S_GC]   = 1'b1;
        if (e.stop) n[S_STOP] = 1'b1;
        if (e.demp) n[S_DEMP] = 1'b1;
        if (e.dtx)  n[S_DTX]  = 1'b1;
        if (e.drx)  n[S_DRX]  = 1'b1;
        return n;
    endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync
    import i2c_tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  scl_i,
    input  logic  sda_i,
    output line_t ln
);
    localparam int MSB = STAGES - 1;

    logic [MSB:0] scl_q, sda_q;
    logic         scl_p, sda_p;
    logic         scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[MSB-1:0], scl_i};
            sda_q <= {sda_q[MSB-1:0], sda_i};
            scl_p <= scl_q[MSB];
            sda_p <= sda_q[MSB];
        end
    end

    always_comb begin
        scl_s    = scl_q[MSB];
        sda_s    = sda_q[MSB];
        ln.start = scl_s & scl_p & sda_p & ~sda_s;
        ln.stop  = scl_s & scl_p & ~sda_p & sda_s;
        ln.rise  = scl_s & ~scl_p;
        ln.fall  = ~scl_s & scl_p;
        ln.sda   = sda_s;
    end
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             gc_en,
    input  logic             fnack,
    input  logic             de_pend,
    input  logic             dr_pend,
    input  logic [ADR_W-1:0] own,
    input  logic [DW-1:0]    tx_byte,
    input  line_t            ln,
    output evt_t             evt,
    output logic [DW-1:0]    rx_byte,
    output logic             sda_drv,
    output logic             scl_hold
);
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] LAST = CW'(DW);

    phase_e        ph;
    logic [DW-1:0] sh;
    logic [CW-1:0] cnt;
    logic          rw, active, need_load, mack;
    logic [1:0]    guard;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            sh        <= '0;
            cnt       <= '0;
            rw        <= 1'b0;
            active    <= 1'b0;
            need_load <= 1'b0;
            mack      <= 1'b0;
            guard     <= '0;
            evt       <= '0;
            rx_byte   <= '0;
            sda_drv   <= 1'b0;
        end else begin
            evt   <= '0;
            guard <= {1'b0, guard[1]};
            if (ln.stop) begin
                if (active) evt.stop <= 1'b1;
                active    <= 1'b0;
                ph        <= PH_IDLE;
                sda_drv   <= 1'b0;
                need_load <= 1'b0;
            end else if (ln.start) begin
                active    <= 1'b0;
                ph        <= PH_ADDR;
                cnt       <= '0;
                sda_drv   <= 1'b0;
                need_load <= 1'b0;
            end else begin
                case (ph)
                    PH_ADDR: begin
                        if (ln.rise) begin
                            sh  <= {sh[DW-2:0], ln.sda};
                            cnt <= cnt + 1'b1;
                        end else if (ln.fall && cnt == LAST) begin
                            if (en && addr_hit(sh, own, gc_en)) begin
                                evt.adr <= 1'b1;
                                evt.dir <= sh[0];
                                evt.gc  <= gc_en && (sh == '0);
                                rw      <= sh[0];
                                active  <= 1'b1;
                                sda_drv <= 1'b1;
                                ph      <= PH_AACK;
                            end else begin
                                ph <= PH_SKIP;
                            end
                        end
                    end
                    PH_AACK: begin
                        if (ln.fall) begin
                            sda_drv <= 1'b0;
                            cnt     <= '0;
                            if (rw) begin
                                ph        <= PH_TX;
                                need_load <= 1'b1;
                                evt.demp  <= 1'b1;
                                guard     <= 2'b11;
                            end else begin
                                ph <= PH_RX;
                            end
                        end
                    end
                    PH_RX: begin
                        if (ln.rise) begin
                            sh  <= {sh[DW-2:0], ln.sda};
                            cnt <= cnt + 1'b1;
                        end else if (ln.fall && cnt == LAST) begin
                            rx_byte <= sh;
                            evt.drx <= 1'b1;
                            guard   <= 2'b11;
                            sda_drv <= ~fnack;
                            ph      <= PH_RACK;
                        end
                    end
                    PH_RACK: begin
                        if (ln.fall) begin
                            sda_drv <= 1'b0;
                            cnt     <= '0;
                            ph      <= PH_RX;
                        end
                    end
                    PH_TX: begin
                        if (need_load) begin
                            if (guard == '0 && !de_pend) begin
                                sh        <= tx_byte;
                                need_load <= 1'b0;
                                cnt       <= '0;
                                sda_drv   <= ~tx_byte[DW-1];
                            end
                        end else if (ln.rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (ln.fall) begin
                            if (cnt == LAST) begin
                                sda_drv <= 1'b0;
                                evt.dtx <= 1'b1;
                                ph      <= PH_TACK;
                            end else begin
                                sh      <= {sh[DW-2:0], 1'b0};
                                sda_drv <= ~sh[DW-2];
                            end
                        end
                    end
                    PH_TACK: begin
                        if (ln.rise) begin
                            mack <= ~ln.sda;
                        end else if (ln.fall) begin
                            if (mack) begin
                                ph        <= PH_TX;
                                need_load <= 1'b1;
                                evt.demp  <= 1'b1;
                                guard     <= 2'b11;
                            end else begin
                                ph <= PH_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        scl_hold = ((ph == PH_RACK) && (guard != '0 || dr_pend)) ||
                   ((ph == PH_TX) && need_load);
    end
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
    import i2c_tgt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  evt_t             evt,
    input  logic [DW-1:0]    rx_byte,
    output logic [DW-1:0]    rdata,
    output logic [NCTL-1:0]  ctrl,
    output logic [NST-1:0]   st,
    output logic [NST-1:0]   ien,
    output logic [ADR_W-1:0] own,
    output logic [DW-1:0]    tx_byte,
    output logic             irq
);
    logic [NST-1:0] clr;

    always_comb begin
        clr = (wr && addr == OFS_STAT) ? ~wdata[NST-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            st      <= '0;
            ien     <= '0;
            own     <= '0;
            tx_byte <= '0;
        end else begin
            st <= stat_next(st, clr, evt);
            if (wr) begin
                case (addr)
                    OFS_CTRL: ctrl    <= wdata[NCTL-1:0];
                    OFS_IEN:  ien     <= wdata[NST-1:0];
                    OFS_OWN:  own     <= wdata[ADR_W-1:0];
                    OFS_DATA: tx_byte <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (addr)
            OFS_CTRL: rdata = DW'(ctrl);
            OFS_STAT: rdata = DW'(st);
            OFS_IEN:  rdata = DW'(ien);
            OFS_OWN:  rdata = DW'(own);
            OFS_DATA: rdata = rx_byte;
            default:  rdata = '0;
        endcase
        irq = |(st & ien);
    end
endmodule

// File: rtl/i2c_tgt_evt.sv
module i2c_tgt_evt
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          scl_oe,
    output logic          sda_oe,
    output logic          irq
);
    line_t            ln;
    evt_t             evt;
    logic [DW-1:0]    rx_byte, tx_byte;
    logic [NCTL-1:0]  ctrl_q;
    logic [NST-1:0]   stat_q, ien_q;
    logic [ADR_W-1:0] own_q;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ln    (ln)
    );

    i2c_tgt_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .en       (ctrl_q[C_EN]),
        .gc_en    (ctrl_q[C_GCEN]),
        .fnack    (ctrl_q[C_NACK]),
        .de_pend  (stat_q[S_DEMP]),
        .dr_pend  (stat_q[S_DRX]),
        .own      (own_q),
        .tx_byte  (tx_byte),
        .ln       (ln),
        .evt      (evt),
        .rx_byte  (rx_byte),
        .sda_drv  (sda_oe),
        .scl_hold (scl_oe)
    );

    i2c_tgt_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .evt     (evt),
        .rx_byte (rx_byte),
        .rdata   (reg_rdata),
        .ctrl    (ctrl_q),
        .st      (stat_q),
        .ien     (ien_q),
        .own     (own_q),
        .tx_byte (tx_byte),
        .irq     (irq)
    );
endmodule

// File: rtl/i2c_tgt_evt_chk.sv
module i2c_tgt_evt_chk
    import i2c_tgt_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            reg_wr,
    input logic [AW-1:0]   reg_addr,
    input logic [DW-1:0]   reg_wdata,
    input logic [NST-1:0]  st,
    input logic [NST-1:0]  ie,
    input logic [NCTL-1:0] ctrl,
    input logic            scl_oe,
    input logic            sda_oe,
    input logic            irq
);
    logic [NST-1:0] clr_mask;
    logic           ctrl_wr;

    always_comb begin
        clr_mask = (reg_wr && reg_addr == OFS_STAT) ? ~reg_wdata[NST-1:0] : '0;
        ctrl_wr  = reg_wr && reg_addr == OFS_CTRL;
    end

    p_quiet_r1: assert property (@(posedge clk)
        rst |=> (st == '0 && !irq && !scl_oe && !sda_oe));

    p_keep_r10: assert property (@(posedge clk) disable iff (rst)
        ((($past(st) & ~$past(clr_mask)) & ~st) == '0));

    p_release_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_oe) |-> (!st[S_DRX] && !st[S_DEMP]));

    p_nack_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(ctrl[C_NACK]) && !$past(ctrl_wr)) |-> ctrl[C_NACK]);

    p_gc_gate_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(st[S_GC]) |-> ctrl[C_GCEN]);

    p_irq_off_r11: assert property (@(posedge clk) disable iff (rst)
        (ie == '0) |-> !irq);
endmodule

bind i2c_tgt_evt i2c_tgt_evt_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .st        (stat_q),
    .ie        (ien_q),
    .ctrl      (ctrl_q),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .irq       (irq)
);

// File: tb/i2c_tgt_evt_tb.sv
module i2c_tgt_evt_tb;
    localparam int HP  = 20;
    localparam logic [6:0] OWN = 7'h2A;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       scl_oe, sda_oe, irq;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic       scl_bus, sda_bus;

    int n_chk = 0;
    int n_bad = 0;

    assign scl_bus = m_scl & ~scl_oe;
    assign sda_bus = m_sda & ~sda_oe;

    always #10 clk = ~clk;

    i2c_tgt_evt u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_i(scl_bus),
        .sda_i(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sw_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic sw_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic scl_up();
        m_scl = 1'b1;
        @(negedge clk);
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic r);
        m_sda = b;
        wait_n(HP);
        scl_up();
        wait_n(HP);
        r = sda_bus;
        m_scl = 1'b0;
        wait_n(6);
    endtask

    task automatic m_start();
        m_sda = 1'b1; wait_n(HP);
        scl_up(); wait_n(HP);
        m_sda = 1'b0; wait_n(HP);
        m_scl = 1'b0; wait_n(HP);
    endtask

    task automatic m_stop();
        m_sda = 1'b0; wait_n(HP);
        scl_up(); wait_n(HP);
        m_sda = 1'b1; wait_n(HP);
    endtask

    task automatic m_wbyte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
        clk_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic m_rbyte(input logic give_ack, output logic [7:0] b);
        logic r;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, r);
            b = {b[6:0], r};
        end
        clk_bit(~give_ack, r);
    endtask

    task automatic svc_rx(output logic [7:0] d, output logic held);
        logic [7:0] s;
        s = '0;
        for (int k = 0; k < 4000 && !s[1]; k++) sw_rd(3'd1, s);
        held = scl_oe;
        sw_rd(3'd4, d);
        sw_wr(3'd1, 8'hFD);
    endtask

    task automatic svc_tx(input logic [7:0] d, output logic held);
        logic [7:0] s;
        s = '0;
        for (int k = 0; k < 4000 && !s[3]; k++) sw_rd(3'd1, s);
        held = scl_oe;
        sw_wr(3'd4, d);
        sw_wr(3'd1, 8'hF7);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v, got;
        logic       ack, held;
        logic [7:0] wbytes [4];
        wbytes[0] = 8'h00; wbytes[1] = 8'hFF; wbytes[2] = 8'hA5; wbytes[3] = 8'h5A;

        wait_n(5);
        rst = 1'b0;
        wait_n(2);
        // R1 reset state
        sw_rd(3'd0, v); chk("R1 ctrl", v, 0);
        sw_rd(3'd1, v); chk("R1 status", v, 0);
        sw_rd(3'd3, v); chk("R1 own", v, 0);
        chk("R1 lines", {scl_oe, sda_oe, irq}, 0);

        // R12 readback
        sw_wr(3'd0, 8'hFF); sw_rd(3'd0, v); chk("R12 ctrl", v, 8'h0F);
        sw_wr(3'd3, 8'hFF); sw_rd(3'd3, v); chk("R12 own", v, 8'h7F);
        sw_wr(3'd3, {1'b0, OWN}); sw_rd(3'd3, v); chk("R12 own", v, OWN);
        sw_wr(3'd0, 8'h04);

        // R2 exhaustive address sweep, write direction, general call off
        for (int a = 0; a < 128; a++) begin
            m_start();
            m_wbyte({a[6:0], 1'b0}, ack);
            m_stop();
            chk("R2 ack", ack, (a == OWN) ? 1 : 0);
            sw_rd(3'd1, v);
            // R3/R9: matched -> address bit and stop bit; otherwise nothing
            chk("R9 status", v, (a == OWN) ? 8'h11 : 8'h00);
            if (a == OWN) sw_wr(3'd1, 8'h00);
        end

        // R4 general call enabled
        sw_wr(3'd0, 8'h06);
        m_start(); m_wbyte(8'h00, ack); m_stop();
        chk("R4 gc ack", ack, 1);
        sw_rd(3'd1, v); chk("R4 gc status", v, 8'h51);
        sw_wr(3'd1, 8'h00);

        // R2 interface disabled
        sw_wr(3'd0, 8'h00);
        m_start(); m_wbyte({OWN, 1'b0}, ack); m_stop();
        chk("R2 disabled ack", ack, 0);
        sw_rd(3'd1, v); chk("R9 no stop when unaddressed", v, 0);

        // R5/R6 write transfer
        sw_wr(3'd0, 8'h04);
        m_start(); m_wbyte({OWN, 1'b0}, ack);
        chk("R2 write addr ack", ack, 1);
        sw_rd(3'd1, v); chk("R3 write dir", v, 8'h01);
        for (int i = 0; i < 4; i++) begin
            fork
                m_wbyte(wbytes[i], ack);
                svc_rx(got, held);
            join
            chk("R5 data", got, wbytes[i]);
            chk("R5 ack", ack, 1);
            chk("R6 hold rx", held, 1);
        end
        // R7 forced NACK
        sw_wr(3'd0, 8'h05);
        fork
            m_wbyte(8'h77, ack);
            svc_rx(got, held);
        join
        chk("R7 nack", ack, 0);
        chk("R7 data", got, 8'h77);
        sw_rd(3'd0, v); chk("R7 sticky", v, 8'h05);
        sw_wr(3'd0, 8'h04);
        m_stop();
        sw_rd(3'd1, v); chk("R9 stop", v, 8'h11);

        // R10 / R11
        chk("R11 irq none enabled", irq, 0);
        sw_wr(3'd2, 8'h10); wait_n(1);
        chk("R11 irq stop", irq, 1);
        sw_wr(3'd1, 8'hFF); sw_rd(3'd1, v); chk("R10 write ones", v, 8'h11);
        sw_wr(3'd1, 8'hEF); sw_rd(3'd1, v); chk("R10 clear one", v, 8'h01);
        chk("R11 irq cleared", irq, 0);
        sw_wr(3'd2, 8'h01); wait_n(1);
        chk("R11 irq addr", irq, 1);
        sw_wr(3'd2, 8'h00);
        sw_wr(3'd1, 8'h00);

        // R8 read transfer
        m_start(); m_wbyte({OWN, 1'b1}, ack);
        chk("R2 read addr ack", ack, 1);
        sw_rd(3'd1, v); chk("R3 read dir", v, 8'h29);
        fork
            m_rbyte(1'b1, got);
            svc_tx(8'hC3, held);
        join
        chk("R8 byte1", got, 8'hC3);
        chk("R6 hold tx", held, 1);
        sw_rd(3'd1, v); chk("R8 sent+empty", v, 8'h2D);
        fork
            m_rbyte(1'b0, got);
            svc_tx(8'h3C, held);
        join
        chk("R8 byte2", got, 8'h3C);
        m_stop();
        sw_rd(3'd1, v); chk("R8 final status", v, 8'h35);
        chk("R6 released", scl_oe, 0);

        summary();
        $finish;
    end
endmodule